// File: doc/BRIEF.md
# Interrupt Trigger Sense and Pending Flags

This block is the input stage of a small interrupt controller. Each of `NUM_SRC` request lines has its own trigger sense: level, falling edge, rising edge or both edges. Every clock the stage samples each line, which must already be synchronous. It compares the line with the sample it stored on the previous cycle and keeps one pending flag per source.

A downstream arbiter receives three vectors:
- the pending flags;
- a one-cycle issue strobe for each qualifying event;
- a one-cycle withdraw strobe, raised when a level-sensed request goes away, so the arbiter can cancel a request that is still outstanding.

Software reaches the stage through a byte-wide register port. It can clear latched edge flags and read them back, and it can reprogram the sense of the upper group of sources (indices from `PIN_BASE` up). The lower sources keep the sense they were given at reset. The arbiter can also clear an edge flag by presenting an acknowledge together with the source index.

Top module: `irq_sense_stage`

## Requirements
- R1: Sense codes are 2'b00 level, 2'b01 falling edge, 2'b10 rising edge and 2'b11 both edges. For source `PIN_BASE+k`, the code is written and read in bits 3:2 of control byte k. Every other bit of a control byte reads as 0.
- R2: In rising mode, a sample of 1 that follows a sample of 0 drives the source's issue bit high for exactly one cycle after that clock edge and sets its pending bit at the same edge.
- R3: In falling mode, a sample of 0 that follows a sample of 1 gives the same issue pulse and pending set. A 0-to-1 change has no effect.
- R4: In both-edges mode, every change of the sampled line gives an issue pulse and sets pending, even when pending is already set.
- R5: The stored previous sample is refreshed on every clock in every mode, so each transition gives exactly one issue pulse and a held line gives none.
- R6: In level mode, pending equals the last sample. Issue pulses when pending goes from 0 to 1. When the line is sampled low while pending is set, pending clears at that edge and withdraw pulses for one cycle.
- R7: A register write with bit 0 equal to 0 to a source's pending byte clears its pending flag in any edge mode. A write with bit 0 equal to 1, or any write to a level-mode source, leaves the flag unchanged.
- R8: `ack_valid_i` with `ack_idx_i` clears that source's pending flag at the next edge if the source is in an edge mode. Level-mode sources ignore it.
- R9: If a qualifying edge and a clear (write or acknowledge) reach the same source in the same cycle, the flag ends up set.
- R10: Synchronous reset clears pending, issue, withdraw and every stored sample. It sets each source to rising mode, or to level mode where its `LEVEL_INIT` bit is 1.
- R11: Control writes with an index at or above `NUM_SRC-PIN_BASE` change nothing and read back as 0.
- R12: Address bit `AW-1` equal to 0 selects the pending byte of source `addr[IDX_W-1:0]`, which reads the flag in bit 0 with the other bits 0. Address bit `AW-1` equal to 1 selects a control byte. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | NUM_SRC | Synchronized request lines |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | AW | Register address: region bit on top, index below |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| ack_valid_i | input | 1 | Acknowledge from the arbiter |
| ack_idx_i | input | IDX_W | Source index being acknowledged |
| pending_o | output | NUM_SRC | Pending flags |
| issue_o | output | NUM_SRC | One-cycle request strobes |
| withdraw_o | output | NUM_SRC | One-cycle level-withdrawal strobes |

## Verification
The bench builds the stage with eight sources and `PIN_BASE` of 4, so the fixed group and the programmable group each have four members. `LEVEL_INIT` marks source 1 (fixed group) and source 5 (programmable group) as level-sensed, which puts a reset-time level source on each side of the boundary. With a 3-bit index and only four pins, control indices 4 to 7 exist on the address port but name no source, so the ignored-write case is reachable. Each of the four sense modes is then exercised on its own lane within a single eight-bit vector.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    typedef enum logic [1:0] {
        SENSE_LEVEL = 2'b00,
        SENSE_FALL  = 2'b01,
        SENSE_RISE  = 2'b10,
        SENSE_BOTH  = 2'b11
    } sense_e;

    // Bit position of the sense code inside a control byte.
    localparam int MODE_LSB = 2;

    typedef struct packed {
        logic pending;
        logic issue;
        logic withdraw;
    } cell_out_t;

    // Qualifying transition for the edge modes.
    function automatic logic edge_hit(sense_e mode, logic prev, logic cur);
        logic hit;
        unique case (mode)
            SENSE_FALL: hit = prev & ~cur;
            SENSE_RISE: hit = ~prev & cur;
            SENSE_BOTH: hit = prev ^ cur;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

    // Control byte image for a given sense code.
    function automatic logic [7:0] mode_byte(sense_e mode);
        logic [7:0] b;
        b = '0;
        b[MODE_LSB +: 2] = mode;
        return b;
    endfunction

endpackage

// File: rtl/irq_sense_cell.sv
module irq_sense_cell
    import irq_sense_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      line_i,
    input  sense_e    mode_i,
    input  logic      clr_i,
    output cell_out_t st_o
);

    logic prev_q, pend_q, iss_q, wd_q;
    logic hit, pend_n, iss_n, wd_n;

    always_comb begin
        hit = edge_hit(mode_i, prev_q, line_i);
        if (mode_i == SENSE_LEVEL) begin
            pend_n = line_i;
            iss_n  = line_i & ~pend_q;
            wd_n   = ~line_i & pend_q;
        end else begin
            // A new edge outranks a clear arriving in the same cycle.
            pend_n = hit | (pend_q & ~clr_i);
            iss_n  = hit;
            wd_n   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
            iss_q  <= 1'b0;
            wd_q   <= 1'b0;
        end else begin
            prev_q <= line_i;
            pend_q <= pend_n;
            iss_q  <= iss_n;
            wd_q   <= wd_n;
        end
    end

    assign st_o = '{pending: pend_q, issue: iss_q, withdraw: wd_q};

    a_r2_rise_sets: assert property (@(posedge clk) disable iff (rst)
        (mode_i == SENSE_RISE && !prev_q && line_i) |=> (iss_q && pend_q));

    a_r3_fall_sets: assert property (@(posedge clk) disable iff (rst)
        (mode_i == SENSE_FALL && prev_q && !line_i) |=> (iss_q && pend_q));

    a_r4_both_sets: assert property (@(posedge clk) disable iff (rst)
        (mode_i == SENSE_BOTH && (prev_q != line_i)) |=> (iss_q && pend_q));

    a_r6_withdraw_drops: assert property (@(posedge clk) disable iff (rst)
        wd_q |-> !pend_q);

    a_r6_withdraw_level_only: assert property (@(posedge clk) disable iff (rst)
        (mode_i != SENSE_LEVEL) |=> !wd_q);

    a_r7_edge_flag_holds: assert property (@(posedge clk) disable iff (rst)
        (mode_i != SENSE_LEVEL && pend_q && !clr_i) |=> pend_q);

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        (mode_i != SENSE_LEVEL && iss_q && $stable(line_i)) |=> !iss_q);

endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
    import irq_sense_pkg::*;
#(
    parameter int                  NUM_SRC    = 80,
    parameter int                  PIN_BASE   = 64,
    parameter logic [NUM_SRC-1:0]  LEVEL_INIT = '0,
    localparam int                 IDX_W      = $clog2(NUM_SRC),
    localparam int                 AW         = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [7:0]           wdata_i,
    input  logic                 ack_valid_i,
    input  logic [IDX_W-1:0]     ack_idx_i,
    input  logic [NUM_SRC-1:0]   pending_i,
    output sense_e [NUM_SRC-1:0] mode_o,
    output logic [NUM_SRC-1:0]   clr_o,
    output logic [7:0]           rdata_o
);

    localparam int PIN_CNT = NUM_SRC - PIN_BASE;

    logic             ctl_sel;
    logic [IDX_W-1:0] sel_idx;
    logic             unused_wdata;

    assign ctl_sel      = addr_i[AW-1];
    assign sel_idx      = addr_i[IDX_W-1:0];
    assign unused_wdata = ^{wdata_i[7:4], wdata_i[1]};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_mode
        localparam sense_e RST_MODE = LEVEL_INIT[i] ? SENSE_LEVEL : SENSE_RISE;
        if (i < PIN_BASE) begin : g_fixed
            assign mode_o[i] = RST_MODE;
        end else begin : g_prog
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i - PIN_BASE);
            sense_e mode_q;
            always_ff @(posedge clk) begin
                if (rst)
                    mode_q <= RST_MODE;
                else if (wr_i && ctl_sel && sel_idx == MY_IDX)
                    mode_q <= sense_e'(wdata_i[MODE_LSB +: 2]);
            end
            assign mode_o[i] = mode_q;
        end
    end

    always_comb begin
        clr_o   = '0;
        rdata_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (wr_i && !ctl_sel && sel_idx == IDX_W'(i) && !wdata_i[0])
                clr_o[i] = 1'b1;
            if (ack_valid_i && ack_idx_i == IDX_W'(i))
                clr_o[i] = 1'b1;
            if (!ctl_sel && sel_idx == IDX_W'(i))
                rdata_o = {7'b0, pending_i[i]};
        end
        for (int k = 0; k < PIN_CNT; k++) begin
            if (ctl_sel && sel_idx == IDX_W'(k))
                rdata_o = mode_byte(mode_o[PIN_BASE + k]);
        end
    end

    a_r12_pending_byte_shape: assert property (@(posedge clk) disable iff (rst)
        !ctl_sel |-> (rdata_o[7:1] == 7'b0));

    a_r1_control_byte_shape: assert property (@(posedge clk) disable iff (rst)
        ctl_sel |-> (rdata_o[7:4] == 4'b0 && rdata_o[1:0] == 2'b0));

endmodule

// File: rtl/irq_sense_stage.sv
module irq_sense_stage
    import irq_sense_pkg::*;
#(
    parameter int                  NUM_SRC    = 80,
    parameter int                  PIN_BASE   = 64,
    parameter logic [NUM_SRC-1:0]  LEVEL_INIT = '0,
    localparam int                 IDX_W      = $clog2(NUM_SRC),
    localparam int                 AW         = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] line_i,
    input  logic               reg_wr_i,
    input  logic [AW-1:0]      reg_addr_i,
    input  logic [7:0]         reg_wdata_i,
    output logic [7:0]         reg_rdata_o,
    input  logic               ack_valid_i,
    input  logic [IDX_W-1:0]   ack_idx_i,
    output logic [NUM_SRC-1:0] pending_o,
    output logic [NUM_SRC-1:0] issue_o,
    output logic [NUM_SRC-1:0] withdraw_o
);

    sense_e [NUM_SRC-1:0] mode;
    logic   [NUM_SRC-1:0] clr;
    cell_out_t            cst [NUM_SRC];

    irq_sense_regs #(
        .NUM_SRC    (NUM_SRC),
        .PIN_BASE   (PIN_BASE),
        .LEVEL_INIT (LEVEL_INIT)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_i        (reg_wr_i),
        .addr_i      (reg_addr_i),
        .wdata_i     (reg_wdata_i),
        .ack_valid_i (ack_valid_i),
        .ack_idx_i   (ack_idx_i),
        .pending_i   (pending_o),
        .mode_o      (mode),
        .clr_o       (clr),
        .rdata_o     (reg_rdata_o)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_sense_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .line_i (line_i[i]),
            .mode_i (mode[i]),
            .clr_i  (clr[i]),
            .st_o   (cst[i])
        );
        assign pending_o[i]  = cst[i].pending;
        assign issue_o[i]    = cst[i].issue;
        assign withdraw_o[i] = cst[i].withdraw;
    end

    a_r10_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (pending_o == '0 && issue_o == '0 && withdraw_o == '0));

endmodule

// File: tb/irq_sense_stage_tb.sv
module irq_sense_stage_tb;

    localparam int N  = 8;
    localparam int PB = 4;

    typedef struct packed {
        logic [7:0] line;
        logic       wr;
        logic [3:0] addr;
        logic [7:0] wdata;
        logic       ackv;
        logic [2:0] ackidx;
        logic [7:0] pend;
        logic [7:0] iss;
        logic [7:0] wd;
        logic [7:0] req;
    } step_t;

    // Sources: 0 rise, 1 level, 2 rise, 3 rise (fixed); 4 fall, 5 level, 6 both, 7 rise (after setup).
    localparam step_t STEPS [21] = '{
        '{8'h01, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h01, 8'h01, 8'h00, 8'd2},  // R2 rise on 0
        '{8'h01, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h01, 8'h00, 8'h00, 8'd5},  // R5 held line
        '{8'h11, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h01, 8'h00, 8'h00, 8'd3},  // R3 rise ignored on 4
        '{8'h01, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h11, 8'h10, 8'h00, 8'd3},  // R3 fall on 4
        '{8'h41, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h51, 8'h40, 8'h00, 8'd4},  // R4 up on 6
        '{8'h01, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h51, 8'h40, 8'h00, 8'd4},  // R4 down on 6
        '{8'h03, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h53, 8'h02, 8'h00, 8'd6},  // R6 level high
        '{8'h03, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h53, 8'h00, 8'h00, 8'd6},  // R6 held high
        '{8'h01, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h51, 8'h00, 8'h02, 8'd6},  // R6 withdraw
        '{8'h01, 1'b1, 4'h0, 8'h00, 1'b0, 3'd0, 8'h50, 8'h00, 8'h00, 8'd7},  // R7 clear 0
        '{8'h01, 1'b1, 4'h4, 8'h01, 1'b0, 3'd0, 8'h50, 8'h00, 8'h00, 8'd7},  // R7 write 1 kept
        '{8'h03, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h52, 8'h02, 8'h00, 8'd6},  // R6 level again
        '{8'h03, 1'b1, 4'h1, 8'h00, 1'b0, 3'd0, 8'h52, 8'h00, 8'h00, 8'd7},  // R7 level ignores
        '{8'h03, 1'b0, 4'h0, 8'h00, 1'b1, 3'd1, 8'h52, 8'h00, 8'h00, 8'd8},  // R8 level ignores ack
        '{8'h03, 1'b0, 4'h0, 8'h00, 1'b1, 3'd4, 8'h42, 8'h00, 8'h00, 8'd8},  // R8 ack clears 4
        '{8'h43, 1'b0, 4'h0, 8'h00, 1'b1, 3'd6, 8'h42, 8'h40, 8'h00, 8'd9},  // R9 set wins
        '{8'h41, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h40, 8'h00, 8'h02, 8'd6},  // R6 withdraw
        '{8'h41, 1'b1, 4'h6, 8'h00, 1'b0, 3'd0, 8'h00, 8'h00, 8'h00, 8'd7},  // R7 clear 6
        '{8'h45, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h04, 8'h04, 8'h00, 8'd2},  // R2 rise on 2
        '{8'hCD, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'h8C, 8'h88, 8'h00, 8'd2},  // R2 two at once
        '{8'h00, 1'b0, 4'h0, 8'h00, 1'b0, 3'd0, 8'hCC, 8'h40, 8'h00, 8'd4}   // R4 only 6 fires
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] line = '0;
    logic         wr = 1'b0;
    logic [3:0]   addr = '0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic         ackv = 1'b0;
    logic [2:0]   ackidx = '0;
    logic [N-1:0] pend, iss, wd;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    irq_sense_stage #(
        .NUM_SRC    (N),
        .PIN_BASE   (PB),
        .LEVEL_INIT (8'b0010_0010)
    ) u_dut (
        .clk         (clk),
        .rst         (rst),
        .line_i      (line),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .ack_valid_i (ackv),
        .ack_idx_i   (ackidx),
        .pending_o   (pend),
        .issue_o     (iss),
        .withdraw_o  (wd)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, input string req, input logic [7:0] exp);
        @(negedge clk);
        wr = 1'b0; addr = a;
        #1;
        check(req, "read", rdata, exp);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state and default modes
        check("R10", "pending", pend, 8'h00);
        check("R10", "issue", iss, 8'h00);
        check("R10", "withdraw", wd, 8'h00);
        reg_read(4'h8, "R10", 8'h08);   // source 4 rising
        reg_read(4'h9, "R10", 8'h00);   // source 5 level

        // R1 programming of the pin group
        reg_write(4'h8, 8'h04);         // source 4 falling
        reg_write(4'hA, 8'h0C);         // source 6 both
        reg_write(4'h9, 8'hF3);         // source 5 stays level, junk bits
        reg_read(4'h8, "R1", 8'h04);
        reg_read(4'hA, "R1", 8'h0C);
        reg_read(4'h9, "R1", 8'h00);
        reg_read(4'hB, "R1", 8'h08);
        // R11 control index beyond the pin group
        reg_write(4'hC, 8'h0C);
        reg_read(4'hC, "R11", 8'h00);
        reg_read(4'hB, "R11", 8'h08);

        for (int s = 0; s < 21; s++) begin
            @(negedge clk);
            line   = STEPS[s].line;
            wr     = STEPS[s].wr;
            addr   = STEPS[s].addr;
            wdata  = STEPS[s].wdata;
            ackv   = STEPS[s].ackv;
            ackidx = STEPS[s].ackidx;
            @(posedge clk);
            #1;
            check($sformatf("R%0d step %0d", STEPS[s].req, s), "pending", pend, STEPS[s].pend);
            check($sformatf("R%0d step %0d", STEPS[s].req, s), "issue", iss, STEPS[s].iss);
            check($sformatf("R%0d step %0d", STEPS[s].req, s), "withdraw", wd, STEPS[s].wd);
        end
        @(negedge clk);
        wr = 1'b0; ackv = 1'b0;

        // R12 pending bytes through the register port
        reg_read(4'h7, "R12", 8'h01);
        reg_read(4'h6, "R12", 8'h01);
        reg_read(4'h1, "R12", 8'h00);

        // R10 reset restores defaults mid-run
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10", "pending after reset", pend, 8'h00);
        reg_read(4'h8, "R10", 8'h08);
        reg_read(4'hA, "R10", 8'h08);

        finish_run();
    end

endmodule